// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block gathers seven single-cycle event pulses from the interrupt sources of a peripheral adapter. Those sources are two counters, two control inputs on each of the two port sides, and the serial shifter. Each pulse sets a sticky flag bit. A separate mask register decides which flags may raise the shared, active-low interrupt request. Software reads the pending flags and the mask through a small register window. It acknowledges a flag by writing a one to its bit.

The mask is never loaded whole. Each write either turns on or turns off the bits selected in the written byte, and data bit 7 chooses which. Software can therefore change one source's enable without reading the mask first. The top bit of the flag register is not stored. It is computed on every read from the current flags and mask, and it shows whether the request line is active.

Top module: `irq_flag_ctrl`

## Requirements
- R1: While reset is high at a rising clock edge, all seven flags and all seven enables are cleared, so the request output `irq_n` reads 1 in the cycle after reset.
- R2: A high source pulse at a clock edge sets its flag at that edge. The bit positions are: bit 6 primary timer, bit 5 secondary timer, bit 4 port-B control 1, bit 3 port-B control 2, bit 2 shifter, bit 1 port-A control 1, bit 0 port-A control 2.
- R3: A flag stays set until a write to address 0xD carries a 1 in its bit position, which clears it. A 0 in the written bit leaves the flag unchanged, and so does data bit 7.
- R4: When a source pulse and a clearing write reach the same flag at the same edge, the flag ends up set.
- R5: A write to address 0xE with data bit 7 = 1 sets each enable whose data bit (6..0) is 1 and leaves the other enables unchanged.
- R6: A write to address 0xE with data bit 7 = 0 clears each enable whose data bit (6..0) is 1 and leaves the other enables unchanged.
- R7: Reading address 0xD returns the flags in bits 6..0. Bit 7 is 1 exactly when some flag and its enable are both 1.
- R8: `irq_n` is 0 exactly when some flag and its enable are both 1. It follows the registers with no added delay.
- R9: Reading address 0xE returns the enables in bits 6..0, with bit 7 always 1.
- R10: `rdata` is 0 when `rd_en` is low or the address is neither 0xD nor 0xE. Writes to any other address change no flag and no enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tmr_pri_evt | input | 1 | Primary timer event pulse (flag bit 6) |
| tmr_sec_evt | input | 1 | Secondary timer event pulse (flag bit 5) |
| portb_ctl1_evt | input | 1 | Port-B control input 1 event (flag bit 4) |
| portb_ctl2_evt | input | 1 | Port-B control input 2 event (flag bit 3) |
| ser_done_evt | input | 1 | Shifter event pulse (flag bit 2) |
| porta_ctl1_evt | input | 1 | Port-A control input 1 event (flag bit 1) |
| porta_ctl2_evt | input | 1 | Port-A control input 2 event (flag bit 0) |
| reg_sel | input | 4 | Register address |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The bench visits every pairing of the 128 flag patterns with the 128 enable patterns. It checks the summary bit and `irq_n` for each pair, so a summary built from the flags alone, or from the wrong bit pairing, fails. It also clears flags while a pulse hits the same bit. A design that gave the clear priority would lose the event.

Writes with bit 7 low and high check that the other enables hold their values. A design that loaded the mask whole, or ignored bit 7, would corrupt them. Writes to the flag address with zeros and stray writes to other addresses check that nothing changes. A design that decoded the address loosely would drop live flags.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int NSRC = 7;

    // Packed order sets the flag bit of each source (msb = bit 6).
    typedef struct packed {
        logic tmr_pri;
        logic tmr_sec;
        logic portb_c1;
        logic portb_c2;
        logic ser_done;
        logic porta_c1;
        logic porta_c2;
    } irq_src_t;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_FLAG  = 2'd1,
        ACC_MASK  = 2'd2,
        ACC_OTHER = 2'd3
    } acc_tgt_e;

    typedef struct packed {
        acc_tgt_e          tgt;
        logic              rd;
        logic              wr;
        logic              mode_set;
        logic [NSRC-1:0]   bits;
    } bus_req_t;

    // Set/clear update of a mask register.
    function automatic logic [NSRC-1:0] mask_update(
        input logic [NSRC-1:0] cur,
        input logic            set_mode,
        input logic [NSRC-1:0] sel
    );
        return set_mode ? (cur | sel) : (cur & ~sel);
    endfunction

    function automatic logic [7:0] pack_status(
        input logic            top,
        input logic [NSRC-1:0] low
    );
        return {top, low};
    endfunction

endpackage

// File: rtl/irq_bus_dec.sv
module irq_bus_dec
    import irq_pkg::*;
#(
    parameter int              ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 4'hD,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 4'hE
) (
    input  logic [ADDR_W-1:0] reg_sel,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [7:0]        wdata,
    output bus_req_t          req
);
    always_comb begin
        req.rd       = rd_en;
        req.wr       = wr_en;
        req.mode_set = wdata[7];
        req.bits     = wdata[NSRC-1:0];
        if (!(rd_en || wr_en))        req.tgt = ACC_NONE;
        else if (reg_sel == FLAG_ADDR) req.tgt = ACC_FLAG;
        else if (reg_sel == MASK_ADDR) req.tgt = ACC_MASK;
        else                           req.tgt = ACC_OTHER;
    end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] set_in,
    input  logic [NSRC-1:0] ack_in,
    output logic [NSRC-1:0] flag_q
);
    // One flop per source; a set in the same cycle as an ack wins.
    for (genvar i = 0; i < NSRC; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)            flag_q[i] <= 1'b0;
            else if (set_in[i]) flag_q[i] <= 1'b1;
            else if (ack_in[i]) flag_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
    import irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            upd,
    input  logic            set_mode,
    input  logic [NSRC-1:0] sel,
    output logic [NSRC-1:0] en_q
);
    always_ff @(posedge clk) begin
        if (rst)      en_q <= '0;
        else if (upd) en_q <= mask_update(en_q, set_mode, sel);
    end
endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux
    import irq_pkg::*;
(
    input  bus_req_t        req,
    input  logic [NSRC-1:0] flag_q,
    input  logic [NSRC-1:0] en_q,
    input  logic            any_pend,
    output logic [7:0]      rdata
);
    always_comb begin
        rdata = '0;
        if (req.rd) begin
            unique case (req.tgt)
                ACC_FLAG: rdata = pack_status(any_pend, flag_q);
                ACC_MASK: rdata = pack_status(1'b1, en_q);
                default:  rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irq_pkg::*;
#(
    parameter int                ADDR_W    = 4,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 4'hD,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 4'hE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tmr_pri_evt,
    input  logic              tmr_sec_evt,
    input  logic              portb_ctl1_evt,
    input  logic              portb_ctl2_evt,
    input  logic              ser_done_evt,
    input  logic              porta_ctl1_evt,
    input  logic              porta_ctl2_evt,
    input  logic [ADDR_W-1:0] reg_sel,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              irq_n
);
    irq_src_t        src;
    bus_req_t        req;
    logic [NSRC-1:0] src_vec;
    logic [NSRC-1:0] ack_vec;
    logic [NSRC-1:0] flag_q;
    logic [NSRC-1:0] en_q;
    logic            mask_upd;
    logic            any_pend;

    always_comb begin
        src.tmr_pri  = tmr_pri_evt;
        src.tmr_sec  = tmr_sec_evt;
        src.portb_c1 = portb_ctl1_evt;
        src.portb_c2 = portb_ctl2_evt;
        src.ser_done = ser_done_evt;
        src.porta_c1 = porta_ctl1_evt;
        src.porta_c2 = porta_ctl2_evt;
    end
    assign src_vec = src;

    irq_bus_dec #(
        .ADDR_W    (ADDR_W),
        .FLAG_ADDR (FLAG_ADDR),
        .MASK_ADDR (MASK_ADDR)
    ) u_dec (
        .reg_sel (reg_sel),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .wdata   (wdata),
        .req     (req)
    );

    assign ack_vec  = (req.wr && req.tgt == ACC_FLAG) ? req.bits : '0;
    assign mask_upd = req.wr && (req.tgt == ACC_MASK);

    irq_flag_bank u_flags (
        .clk    (clk),
        .rst    (rst),
        .set_in (src_vec),
        .ack_in (ack_vec),
        .flag_q (flag_q)
    );

    irq_enable_reg u_mask (
        .clk      (clk),
        .rst      (rst),
        .upd      (mask_upd),
        .set_mode (req.mode_set),
        .sel      (req.bits),
        .en_q     (en_q)
    );

    assign any_pend = |(flag_q & en_q);
    assign irq_n    = ~any_pend;

    irq_read_mux u_rd (
        .req      (req),
        .flag_q   (flag_q),
        .en_q     (en_q),
        .any_pend (any_pend),
        .rdata    (rdata)
    );
endmodule

// File: rtl/irq_flag_ctrl_chk.sv
module irq_flag_ctrl_chk
    import irq_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [NSRC-1:0] src_vec,
    input logic [3:0]      reg_sel,
    input logic            rd_en,
    input logic            wr_en,
    input logic [7:0]      wdata,
    input logic [7:0]      rdata,
    input logic            irq_n,
    input logic [NSRC-1:0] flag_q,
    input logic [NSRC-1:0] en_q
);
    logic flag_wr, mask_wr;
    assign flag_wr = wr_en && reg_sel == 4'hD;
    assign mask_wr = wr_en && reg_sel == 4'hE;

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (flag_q == '0 && en_q == '0 && irq_n));

    p_pulse_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (|src_vec) |=> ((flag_q & $past(src_vec)) == $past(src_vec)));

    p_flag_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!flag_wr && src_vec == '0) |=> $stable(flag_q));

    p_ack_clears_r3: assert property (@(posedge clk) disable iff (rst)
        flag_wr |=> ((flag_q & $past(wdata[NSRC-1:0] & ~src_vec)) == '0));

    p_set_beats_ack_r4: assert property (@(posedge clk) disable iff (rst)
        (flag_wr && (src_vec & wdata[NSRC-1:0]) != '0)
        |=> ((flag_q & $past(src_vec & wdata[NSRC-1:0])) == $past(src_vec & wdata[NSRC-1:0])));

    p_mask_set_r5: assert property (@(posedge clk) disable iff (rst)
        (mask_wr && wdata[7]) |=> ((en_q & $past(wdata[NSRC-1:0])) == $past(wdata[NSRC-1:0])));

    p_mask_clr_r6: assert property (@(posedge clk) disable iff (rst)
        (mask_wr && !wdata[7]) |=> ((en_q & $past(wdata[NSRC-1:0])) == '0));

    p_summary_bit_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && reg_sel == 4'hD) |-> (rdata[7] == !irq_n));

    p_mask_top_bit_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && reg_sel == 4'hE) |-> (rdata[7] && rdata[NSRC-1:0] == en_q));

    p_idle_bus_r10: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rdata == 8'h00));
endmodule

bind irq_flag_ctrl irq_flag_ctrl_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .src_vec (src_vec),
    .reg_sel (reg_sel),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .wdata   (wdata),
    .rdata   (rdata),
    .irq_n   (irq_n),
    .flag_q  (flag_q),
    .en_q    (en_q)
);

// File: tb/tb_irq_flag_ctrl.sv
`timescale 1ns/1ps
module tb_irq_flag_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] src = '0;
    logic [3:0] reg_sel = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [6:0] mf = '0;  // model flags
    logic [6:0] me = '0;  // model enables

    always #2.5 clk = ~clk;

    irq_flag_ctrl dut (
        .clk            (clk),
        .rst            (rst),
        .tmr_pri_evt    (src[6]),
        .tmr_sec_evt    (src[5]),
        .portb_ctl1_evt (src[4]),
        .portb_ctl2_evt (src[3]),
        .ser_done_evt   (src[2]),
        .porta_ctl1_evt (src[1]),
        .porta_ctl2_evt (src[0]),
        .reg_sel        (reg_sel),
        .rd_en          (rd_en),
        .wr_en          (wr_en),
        .wdata          (wdata),
        .rdata          (rdata),
        .irq_n          (irq_n)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // One clock with the given stimulus; the model follows the requirements.
    task automatic step(input logic [6:0] s, input logic w, input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        src = s; wr_en = w; reg_sel = a; wdata = d;
        @(posedge clk);
        if (w && a == 4'hD) mf = mf & ~d[6:0];                          // R3
        if (w && a == 4'hE) me = d[7] ? (me | d[6:0]) : (me & ~d[6:0]); // R5 R6
        mf = mf | s;                                                    // R2 R4
        #1;
        src = '0; wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        rd_en = 1'b1; reg_sel = a;
        #1;
        v = rdata;
        rd_en = 1'b0;
    endtask

    task automatic check_state(input string tag);
        logic [7:0] v;
        logic       pend;
        pend = (mf & me) != 7'd0;
        rd(4'hD, v);
        check({tag, " R7 flag read"}, v, {pend, mf});
        check({tag, " R8 irq_n"}, {7'd0, irq_n}, {7'd0, !pend});
        rd(4'hE, v);
        check({tag, " R9 mask read"}, v, {1'b1, me});
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1 reset state
        check("R1 irq_n after reset", {7'd0, irq_n}, 8'h01);
        check_state("R1");

        // R2: each source alone, with its bit position
        for (int k = 0; k < 7; k++) begin
            step(7'(1 << k), 1'b0, 4'h0, 8'h00);
            rd(4'hD, v);
            check("R2 single source", v, {1'b0, 7'(1 << k)});
            step(7'd0, 1'b1, 4'hD, 8'h7F);
        end

        // R3: write of zeros and of bit 7 alone leaves flags
        step(7'h55, 1'b0, 4'h0, 8'h00);
        step(7'd0, 1'b1, 4'hD, 8'h80);
        check_state("R3 zero-write");
        step(7'd0, 1'b1, 4'hD, 8'h05);
        check_state("R3 partial ack");

        // R4: pulse and ack on same bit, set wins
        step(7'h10, 1'b1, 4'hD, 8'h7F);
        rd(4'hD, v);
        check("R4 set beats ack", v, 8'h10);
        check_state("R4");

        // R5/R6: set then clear subsets, others unchanged
        step(7'd0, 1'b1, 4'hE, 8'h83);
        step(7'd0, 1'b1, 4'hE, 8'hA0);
        check_state("R5 set mode");
        step(7'd0, 1'b1, 4'hE, 8'h01);
        check_state("R6 clear mode");

        // R10: stray writes and reads
        for (int a = 0; a < 16; a++) begin
            if (a != 13 && a != 14) begin
                step(7'd0, 1'b1, 4'(a), 8'hFF);
                rd(4'(a), v);
                check("R10 other address read", v, 8'h00);
            end
        end
        check_state("R10 after stray writes");
        @(negedge clk); rd_en = 1'b0; reg_sel = 4'hD; #1;
        check("R10 idle read bus", rdata, 8'h00);

        // Exhaustive flag x enable sweep (R2 R5 R7 R8 R9)
        for (int f = 0; f < 128; f++) begin
            step(7'd0, 1'b1, 4'hD, 8'h7F);
            step(7'(f), 1'b0, 4'h0, 8'h00);
            for (int e = 0; e < 128; e++) begin
                step(7'd0, 1'b1, 4'hE, 8'h7F);
                step(7'd0, 1'b1, 4'hE, 8'h80 | 8'(e));
                @(negedge clk); rd_en = 1'b1; reg_sel = 4'hD; #1;
                check("R7 sweep summary", rdata, {((mf & me) != 0), mf});
                check("R8 sweep irq_n", {7'd0, irq_n}, {7'd0, (mf & me) == 0});
                rd_en = 1'b0;
            end
        end

        // R1: reset mid-run clears everything
        step(7'h7F, 1'b1, 4'hE, 8'hFF);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; mf = '0; me = '0;
        check("R1 irq_n after second reset", {7'd0, irq_n}, 8'h01);
        check_state("R1 second reset");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule